// File: doc/BRIEF.md
# Multiplexed Address/Data Port Direction Control

This block sets the direction of an 8-bit port whose pins can carry the low byte of a multiplexed processor address/data bus. It works only while a tracking-mode configuration bit is set. An address decoder supplies three selects, each built from one product term. The read select is qualified by the read strobe. When both are true, whatever is present on the port pins is returned onto the processor's bus. The address select is qualified by ALE. When both are true, the bus value is passed out of the port. The write select already contains the write-cycle strobes in its own term, so it drives bus data out of the port with no further gating.

During an address phase, the block samples the bus value on every clock and keeps the last sample taken before ALE drops. That value stays on the port's data path until the next address phase. If a read and an outward transfer are requested together, the read path is suppressed and a clash flag is raised. This ensures the two sides never drive each other.

Top module: `adbus_dir_ctrl`

## Requirements
- R1: With `track_en` low, `bus_oe`, `port_oe` and `clash` stay 0 whatever the selects and strobes do.
- R2: With `track_en`, `sel_rd` and `rd_stb` high and no outward transfer requested, `bus_oe` is 1 and `bus_out` equals `port_in` in the same cycle.
- R3: `sel_rd` without `rd_stb`, or `rd_stb` without `sel_rd`, leaves `bus_oe` at 0.
- R4: With `track_en`, `sel_ale` and `ale` high, `port_oe` is 1 and `port_out` equals `bus_in` in the same cycle.
- R5: `sel_ale` without `ale`, or `ale` without `sel_ale`, does not raise `port_oe`.
- R6: With `track_en` and `sel_wr` high, `port_oe` is 1 and `port_out` equals `bus_in`, whatever `ale` and `rd_stb` are.
- R7: When the read condition of R2 holds together with the condition of R4 or R6, `bus_oe` is 0, `clash` is 1 and the port side still drives.
- R8: While the port is not driving, `port_out` holds the `bus_in` value sampled at the last rising clock edge of the most recent address phase (R4). It stays unchanged until the next address phase.
- R9: While `bus_oe` is 0, `bus_out` reads 0.
- R10: Synchronous active-high `rst` clears the held address to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| track_en | input | 1 | Tracking-mode configuration bit, 1 = enabled |
| sel_rd | input | 1 | Decoder select for the inward (read) direction |
| sel_ale | input | 1 | Decoder select for outward address transfer |
| sel_wr | input | 1 | Decoder select for outward write data, write strobes already included |
| rd_stb | input | 1 | Internal read strobe, active high |
| ale | input | 1 | Address latch enable, active high |
| bus_in | input | 8 | Value on the multiplexed processor bus |
| port_in | input | 8 | Value on the port pins |
| bus_out | output | 8 | Data driven onto the multiplexed bus |
| bus_oe | output | 1 | Output enable for the bus side |
| port_out | output | 8 | Data driven onto the port pins |
| port_oe | output | 1 | Output enable for the port side |
| clash | output | 1 | Read and outward transfer requested together |

## Verification
The bench targets the cases where one qualifier is present without its strobe. A design that ignored a strobe would enable a driver during idle bus cycles. It forces a read to collide with an address phase and with a write select. A design without suppression would raise both enables at once and fight its own pins. It also checks that the held address is the last value sampled before ALE falls, and that it survives later bus traffic. A latch that followed the bus would show the newer value. Finally, it toggles the mode bit with every select active, to catch logic that drives outside tracking mode.

// File: rtl/adbus_dir_pkg.sv
package adbus_dir_pkg;

    localparam int unsigned DIR_N = 3;

    typedef enum logic [1:0] {
        DIR_RD   = 2'd0,
        DIR_ADDR = 2'd1,
        DIR_WR   = 2'd2
    } dir_idx_e;

    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_ADDR  = 2'd1,
        SRC_WDATA = 2'd2
    } port_src_e;

    typedef struct packed {
        logic wr_go;
        logic addr_go;
        logic rd_go;
    } dir_req_t;

    function automatic dir_req_t unpack_req(input logic [DIR_N-1:0] go);
        dir_req_t r;
        r.rd_go   = go[DIR_RD];
        r.addr_go = go[DIR_ADDR];
        r.wr_go   = go[DIR_WR];
        return r;
    endfunction

    function automatic port_src_e pick_src(input dir_req_t r);
        if (r.wr_go)
            return SRC_WDATA;
        else if (r.addr_go)
            return SRC_ADDR;
        return SRC_HOLD;
    endfunction

endpackage

// File: rtl/adbus_dir_qualify.sv
module adbus_dir_qualify
    import adbus_dir_pkg::*;
#(
    parameter int unsigned N = DIR_N
) (
    input  logic         mode_on,
    input  logic [N-1:0] sel,
    input  logic [N-1:0] strobe,
    output logic [N-1:0] go
);
    for (genvar i = 0; i < N; i++) begin : g_qual
        assign go[i] = mode_on & sel[i] & strobe[i];
    end
endmodule

// File: rtl/adbus_addr_hold.sv
module adbus_addr_hold #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (capture)
            q <= d;
    end
endmodule

// File: rtl/adbus_dir_steer.sv
module adbus_dir_steer
    import adbus_dir_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  dir_req_t     req,
    input  logic [W-1:0] bus_in,
    input  logic [W-1:0] port_in,
    input  logic [W-1:0] held_addr,
    output logic [W-1:0] bus_out,
    output logic         bus_oe,
    output logic [W-1:0] port_out,
    output logic         port_oe,
    output logic         clash
);
    port_src_e src;
    logic      outward;

    always_comb begin
        src      = pick_src(req);
        outward  = req.addr_go | req.wr_go;
        clash    = req.rd_go & outward;
        bus_oe   = req.rd_go & ~outward;
        port_oe  = outward;
        bus_out  = bus_oe ? port_in : '0;
        unique case (src)
            SRC_WDATA: port_out = bus_in;
            SRC_ADDR:  port_out = bus_in;
            default:   port_out = held_addr;
        endcase
    end
endmodule

// File: rtl/adbus_dir_ctrl.sv
module adbus_dir_ctrl
    import adbus_dir_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         track_en,
    input  logic         sel_rd,
    input  logic         sel_ale,
    input  logic         sel_wr,
    input  logic         rd_stb,
    input  logic         ale,
    input  logic [W-1:0] bus_in,
    input  logic [W-1:0] port_in,
    output logic [W-1:0] bus_out,
    output logic         bus_oe,
    output logic [W-1:0] port_out,
    output logic         port_oe,
    output logic         clash
);
    logic [DIR_N-1:0] go;
    logic [W-1:0]     held_addr;
    dir_req_t         req;

    // the write select already carries its strobes, so its qualifier is tied high
    adbus_dir_qualify #(.N(DIR_N)) u_qual (
        .mode_on (track_en),
        .sel     ({sel_wr, sel_ale, sel_rd}),
        .strobe  ({1'b1, ale, rd_stb}),
        .go      (go)
    );

    assign req = unpack_req(go);

    adbus_addr_hold #(.W(W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .capture (req.addr_go),
        .d       (bus_in),
        .q       (held_addr)
    );

    adbus_dir_steer #(.W(W)) u_steer (
        .req       (req),
        .bus_in    (bus_in),
        .port_in   (port_in),
        .held_addr (held_addr),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .port_out  (port_out),
        .port_oe   (port_oe),
        .clash     (clash)
    );
endmodule

// File: rtl/adbus_dir_ctrl_chk.sv
module adbus_dir_ctrl_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         track_en,
    input logic         sel_rd,
    input logic         sel_ale,
    input logic         sel_wr,
    input logic         rd_stb,
    input logic         ale,
    input logic [W-1:0] bus_in,
    input logic [W-1:0] port_in,
    input logic [W-1:0] bus_out,
    input logic         bus_oe,
    input logic [W-1:0] port_out,
    input logic         port_oe,
    input logic         clash
);
    // R1
    mode_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !track_en |-> (!bus_oe && !port_oe && !clash));

    // R7
    no_fight_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_oe && port_oe));

    // R7
    clash_blocks_read_chk: assert property (@(posedge clk) disable iff (rst)
        clash |-> (!bus_oe && port_oe));

    // R2
    read_open_chk: assert property (@(posedge clk) disable iff (rst)
        (track_en && sel_rd && rd_stb && !port_oe) |-> (bus_oe && bus_out == port_in));

    // R6
    write_open_chk: assert property (@(posedge clk) disable iff (rst)
        (track_en && sel_wr) |-> (port_oe && port_out == bus_in));

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!port_oe && $past(!port_oe)) |-> $stable(port_out));

    // R9
    bus_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> (bus_out == '0));
endmodule

bind adbus_dir_ctrl adbus_dir_ctrl_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .track_en (track_en),
    .sel_rd   (sel_rd),
    .sel_ale  (sel_ale),
    .sel_wr   (sel_wr),
    .rd_stb   (rd_stb),
    .ale      (ale),
    .bus_in   (bus_in),
    .port_in  (port_in),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe),
    .port_out (port_out),
    .port_oe  (port_oe),
    .clash    (clash)
);

// File: tb/adbus_dir_ctrl_bench.sv
module adbus_dir_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       track_en = 1'b0, sel_rd = 1'b0, sel_ale = 1'b0, sel_wr = 1'b0;
    logic       rd_stb = 1'b0, ale = 1'b0;
    logic [7:0] bus_in = 8'h00, port_in = 8'h00;
    logic [7:0] bus_out, port_out;
    logic       bus_oe, port_oe, clash;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    adbus_dir_ctrl u_adbus_dir_ctrl (
        .clk(clk), .rst(rst), .track_en(track_en),
        .sel_rd(sel_rd), .sel_ale(sel_ale), .sel_wr(sel_wr),
        .rd_stb(rd_stb), .ale(ale), .bus_in(bus_in), .port_in(port_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .port_out(port_out),
        .port_oe(port_oe), .clash(clash)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        sel_rd = 0; sel_ale = 0; sel_wr = 0; rd_stb = 0; ale = 0;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        settle();
        chk("R10 bus_oe", bus_oe, 0);
        chk("R10 port_oe", port_oe, 0);
        chk("R10 held addr", port_out, 8'h00);
    endtask

    task automatic t_mode_off();
        @(negedge clk);
        track_en = 0; sel_rd = 1; sel_ale = 1; sel_wr = 1; rd_stb = 1; ale = 1;
        bus_in = 8'h77; port_in = 8'h88;
        settle();
        chk("R1 bus_oe", bus_oe, 0);
        chk("R1 port_oe", port_oe, 0);
        chk("R1 clash", clash, 0);
        chk("R9 bus_out zero", bus_out, 0);
        @(posedge clk); settle();
        chk("R1 no capture", port_out, 8'h00);
        idle();
        track_en = 1;
    endtask

    task automatic t_read();
        @(negedge clk);
        sel_rd = 1; rd_stb = 1; port_in = 8'h5A;
        settle();
        chk("R2 bus_oe", bus_oe, 1);
        chk("R2 bus_out", bus_out, 8'h5A);
        port_in = 8'hC3; settle();
        chk("R2 bus_out follows", bus_out, 8'hC3);
        rd_stb = 0; settle();
        chk("R3 no strobe", bus_oe, 0);
        chk("R9 bus_out zero", bus_out, 0);
        sel_rd = 0; rd_stb = 1; settle();
        chk("R3 no select", bus_oe, 0);
        idle();
    endtask

    task automatic t_addr();
        @(negedge clk);
        sel_ale = 1; ale = 0; bus_in = 8'h11; settle();
        chk("R5 no ale", port_oe, 0);
        sel_ale = 0; ale = 1; settle();
        chk("R5 no select", port_oe, 0);
        @(posedge clk); settle();
        chk("R5 no capture", port_out, 8'h00);
        @(negedge clk);
        sel_ale = 1; ale = 1; bus_in = 8'h3C; settle();
        chk("R4 port_oe", port_oe, 1);
        chk("R4 port_out", port_out, 8'h3C);
        @(negedge clk);
        bus_in = 8'hA5; settle();
        chk("R4 port_out follows", port_out, 8'hA5);
        @(negedge clk);
        ale = 0; sel_ale = 0; bus_in = 8'h96; settle();
        chk("R8 port_oe off", port_oe, 0);
        chk("R8 held", port_out, 8'hA5);
        @(negedge clk);
        bus_in = 8'h42; port_in = 8'h24; sel_rd = 1; rd_stb = 1; settle();
        chk("R8 held under read", port_out, 8'hA5);
        idle();
        settle();
        chk("R8 still held", port_out, 8'hA5);
    endtask

    task automatic t_write();
        @(negedge clk);
        sel_wr = 1; bus_in = 8'hE7; ale = 0; rd_stb = 0; settle();
        chk("R6 port_oe", port_oe, 1);
        chk("R6 port_out", port_out, 8'hE7);
        @(negedge clk);
        sel_wr = 0; settle();
        chk("R8 hold after write", port_out, 8'hA5);
        idle();
    endtask

    task automatic t_clash();
        @(negedge clk);
        sel_rd = 1; rd_stb = 1; sel_ale = 1; ale = 1; bus_in = 8'h5E; port_in = 8'h01;
        settle();
        chk("R7 addr clash flag", clash, 1);
        chk("R7 addr bus_oe", bus_oe, 0);
        chk("R7 addr port_oe", port_oe, 1);
        @(negedge clk);
        sel_ale = 0; ale = 0; sel_wr = 1; bus_in = 8'h6F; settle();
        chk("R7 wr clash flag", clash, 1);
        chk("R7 wr bus_oe", bus_oe, 0);
        chk("R7 wr port_out", port_out, 8'h6F);
        @(negedge clk);
        sel_wr = 0; settle();
        chk("R7 clash clears", clash, 0);
        chk("R2 read resumes", bus_out, 8'h01);
        idle();
        settle();
        chk("R8 clash capture held", port_out, 8'h5E);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_mode_off();
                t_read();
                t_addr();
                t_write();
                t_clash();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule